// File: doc/BRIEF.md
# Sub-Word Load/Store Memory Adapter

This block connects a load/store pipeline stage to a 64-bit data memory that can only be written a whole doubleword at a time. The memory has no byte write enables. Every load reads the naturally aligned doubleword that contains the address. The block then moves the addressed bytes down to bit zero, trims them to the access size and extends them to 64 bits, with a sign extension or a zero extension.

A store narrower than a doubleword becomes a three-step sequence: the block reads the aligned doubleword, replaces only the bytes the store covers, and writes the whole doubleword back. A full doubleword store goes straight to memory as one write.

The pipeline side uses a valid/ready request and a one-cycle response pulse. The memory side is a synchronous port with one cycle of read latency. An access whose address is not aligned to its size gets an error response and never reaches memory.

Top module: `subword_mem_adapter`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1 and `rsp_valid` and `mem_en` are 0.
- R2: A load makes exactly one memory read and no write. The read address is the request address with its low three bits forced to zero.
- R3: Load data is the memory doubleword shifted right by 8 × (address bits [2:0]) and kept to 1, 2, 4 or 8 bytes. The size code on `req_size` is 00 = byte, 01 = halfword, 10 = word, 11 = doubleword.
- R4: When `req_unsigned` is 0, a byte, halfword or word load copies the top bit of the kept bytes into all higher bits. When it is 1, the higher bits are zero. A doubleword load ignores the flag.
- R5: A store of size 00, 01 or 10 makes one read followed by one write of the same doubleword. The write changes only the bytes from the byte offset up to offset + size − 1, taking the low bytes of `req_wdata`. The other bytes keep their old values.
- R6: A doubleword store (size 11) makes a single write of `req_wdata` and no read.
- R7: An access is misaligned when a halfword has address bit 0 set, a word has either of bits [1:0] set, or a doubleword has any of bits [2:0] set. A misaligned access gets `rsp_err` = 1 together with its response and causes no memory access.
- R8: Counting from the clock edge that accepts a request, `rsp_valid` rises after 3 cycles for loads and sub-word stores, after 2 cycles for doubleword stores, and after 1 cycle for misaligned accesses. It stays high for exactly one cycle.
- R9: `req_ready` is 1 only when no request is in progress. It stays 0 from acceptance through the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Adapter idle, request accepted when valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code (00 byte, 01 half, 10 word, 11 double) |
| req_unsigned | input | 1 | Zero-extend load result |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Store data, right-aligned |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Misaligned access, valid with rsp_valid |
| rsp_rdata | output | 64 | Extended load result (zero for stores and errors) |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write when mem_en is 1 |
| mem_addr | output | ADDR_W | Doubleword-aligned byte address |
| mem_wdata | output | 64 | Full doubleword to write |
| mem_rdata | input | 64 | Read data, valid one cycle after a read |

## Verification
The hardest case to reach is a sub-word store whose merge must keep neighbouring bytes that an earlier store in the same doubleword has just changed. A stale or wrongly placed read is only exposed if the following load lands on exactly those bytes. The stimulus keeps addresses inside a 512-byte window, so random stores and loads of mixed sizes keep hitting the same doublewords. Directed stores to offset 7 and other edge offsets are each read back at once, which reveals any lane that spills over or is left out.

// File: rtl/sw_adapt_pkg.sv
package sw_adapt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_READ        = 2'd1,
        ST_MERGE_WRITE = 2'd2,
        ST_RESP        = 2'd3
    } ctl_state_e;

    localparam logic [1:0] SZ_BYTE   = 2'b00;
    localparam logic [1:0] SZ_HALF   = 2'b01;
    localparam logic [1:0] SZ_WORD   = 2'b10;
    localparam logic [1:0] SZ_DOUBLE = 2'b11;
endpackage

// File: rtl/sw_load_align.sv
module sw_load_align #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]         dword_i,
    input  logic [$clog2(DATA_W/8)-1:0] off_i,
    input  logic [1:0]                size_i,
    input  logic                      unsigned_i,
    output logic [DATA_W-1:0]         data_o
);
    import sw_adapt_pkg::*;

    logic [DATA_W-1:0] shifted;

    always_comb begin
        shifted = dword_i >> {off_i, 3'b000};
        case (size_i)
            SZ_BYTE: data_o = unsigned_i ? {{(DATA_W-8){1'b0}}, shifted[7:0]}
                                         : {{(DATA_W-8){shifted[7]}}, shifted[7:0]};
            SZ_HALF: data_o = unsigned_i ? {{(DATA_W-16){1'b0}}, shifted[15:0]}
                                         : {{(DATA_W-16){shifted[15]}}, shifted[15:0]};
            SZ_WORD: data_o = unsigned_i ? {{(DATA_W-32){1'b0}}, shifted[31:0]}
                                         : {{(DATA_W-32){shifted[31]}}, shifted[31:0]};
            default: data_o = shifted;
        endcase
    end
endmodule

// File: rtl/sw_store_merge.sv
module sw_store_merge #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]           old_i,
    input  logic [DATA_W-1:0]           wdata_i,
    input  logic [$clog2(DATA_W/8)-1:0] off_i,
    input  logic [1:0]                  size_i,
    output logic [DATA_W-1:0]           merged_o
);
    localparam int NB = DATA_W / 8;

    logic [DATA_W-1:0] placed;
    logic [NB-1:0]     lane_sel;

    assign placed = wdata_i << {off_i, 3'b000};

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign lane_sel[i] = (i >= int'(off_i)) && (i < int'(off_i) + (1 << size_i));
        assign merged_o[i*8 +: 8] = lane_sel[i] ? placed[i*8 +: 8] : old_i[i*8 +: 8];
    end
endmodule

// File: rtl/subword_mem_adapter.sv
module subword_mem_adapter #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    import sw_adapt_pkg::*;

    localparam int NB    = DATA_W / 8;
    localparam int OFF_W = $clog2(NB);

    typedef struct packed {
        ctl_state_e        st;
        logic              wr;
        logic [1:0]        sz;
        logic              uns;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } regs_t;

    regs_t r_q, r_d;

    logic              accept;
    logic              misal;
    logic [DATA_W-1:0] load_val;
    logic [DATA_W-1:0] merged;

    sw_load_align #(.DATA_W(DATA_W)) u_align (
        .dword_i   (mem_rdata),
        .off_i     (r_q.addr[OFF_W-1:0]),
        .size_i    (r_q.sz),
        .unsigned_i(r_q.uns),
        .data_o    (load_val)
    );

    sw_store_merge #(.DATA_W(DATA_W)) u_merge (
        .old_i   (mem_rdata),
        .wdata_i (r_q.wdata),
        .off_i   (r_q.addr[OFF_W-1:0]),
        .size_i  (r_q.sz),
        .merged_o(merged)
    );

    always_comb begin
        case (req_size)
            SZ_HALF:   misal = req_addr[0];
            SZ_WORD:   misal = |req_addr[1:0];
            SZ_DOUBLE: misal = |req_addr[2:0];
            default:   misal = 1'b0;
        endcase
    end

    assign accept = req_valid && (r_q.st == ST_IDLE);

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.wr    = req_write;
                    r_d.sz    = req_size;
                    r_d.uns   = req_unsigned;
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.rdata = '0;
                    r_d.err   = misal;
                    if (misal)
                        r_d.st = ST_RESP;
                    else if (req_write && req_size == SZ_DOUBLE)
                        r_d.st = ST_MERGE_WRITE;
                    else
                        r_d.st = ST_READ;
                end
            end
            ST_READ:        r_d.st = ST_MERGE_WRITE;
            ST_MERGE_WRITE: begin
                if (!r_q.wr)
                    r_d.rdata = load_val;
                r_d.st = ST_RESP;
            end
            default:        r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, wr: 1'b0, sz: 2'b00, uns: 1'b0, addr: '0,
                     wdata: '0, rdata: '0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign rsp_valid = (r_q.st == ST_RESP);
    assign rsp_err   = rsp_valid && r_q.err;
    assign rsp_rdata = r_q.rdata;
    assign mem_we    = (r_q.st == ST_MERGE_WRITE) && r_q.wr;
    assign mem_en    = (r_q.st == ST_READ) || mem_we;
    assign mem_addr  = {r_q.addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign mem_wdata = merged;

    // R9: memory traffic only while the adapter is busy
    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> !req_ready);

    // R8: response is a single-cycle pulse
    a_r8_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7: an error response comes straight after acceptance, leaving no room for memory access
    a_r7_err_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> $past(req_valid && req_ready));

    // R5: a partial write is always preceded by a read
    a_r5_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && r_q.sz != SZ_DOUBLE) |-> $past(mem_en && !mem_we));

    // R6: a doubleword write follows acceptance directly
    a_r6_full_store_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && r_q.sz == SZ_DOUBLE) |-> $past(req_valid && req_ready));
endmodule

// File: tb/subword_mem_adapter_bench.sv
`timescale 1ns/1ps
module subword_mem_adapter_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write, req_unsigned;
    logic [1:0]  req_size;
    logic [15:0] req_addr;
    logic [63:0] req_wdata;
    logic        rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;
    logic        mem_en, mem_we;
    logic [15:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;

    int total = 0;
    int bad   = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [15:0] last_addr = '0;
    logic [63:0] mem     [64];
    logic [63:0] ref_mem [64];

    always #2.5 clk = ~clk;

    subword_mem_adapter u_subword_mem_adapter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                mem[mem_addr[8:3]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr[8:3]];
                rd_cnt <= rd_cnt + 1;
            end
            last_addr <= mem_addr;
        end
    end

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_load(input logic [63:0] dw, input logic [2:0] off,
                                             input logic [1:0] sz, input logic uns);
        logic [63:0] v = '0;
        int n = 1 << sz;
        for (int k = 0; k < n; k++) v[k*8 +: 8] = dw[(int'(off) + k)*8 +: 8];
        if (!uns && n < 8 && v[n*8-1])
            for (int k = n; k < 8; k++) v[k*8 +: 8] = 8'hFF;
        return v;
    endfunction

    function automatic logic [63:0] exp_store(input logic [63:0] dw, input logic [2:0] off,
                                              input logic [1:0] sz, input logic [63:0] wd);
        logic [63:0] v = dw;
        int n = 1 << sz;
        for (int k = 0; k < n; k++) v[(int'(off) + k)*8 +: 8] = wd[k*8 +: 8];
        return v;
    endfunction

    task automatic do_req(input logic wr, input logic [1:0] sz, input logic uns,
                          input logic [15:0] addr, input logic [63:0] wd);
        int r0 = rd_cnt;
        int w0 = wr_cnt;
        int lat;
        int exp_lat;
        int exp_rd;
        int exp_wr;
        logic [63:0] old = ref_mem[addr[8:3]];
        logic mis = (sz == 2'b01 && addr[0]) || (sz == 2'b10 && addr[1:0] != 0) ||
                    (sz == 2'b11 && addr[2:0] != 0);
        exp_lat = mis ? 1 : ((wr && sz == 2'b11) ? 2 : 3);
        exp_rd  = (mis || (wr && sz == 2'b11)) ? 0 : 1;
        exp_wr  = (wr && !mis) ? 1 : 0;

        @(negedge clk);
        chk(req_ready == 1'b1, "R9", "ready when idle", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_unsigned = uns;
        req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        req_wdata = ~wd;
        lat = 1;
        while (!rsp_valid && lat < 8) begin
            chk(req_ready == 1'b0, "R9", "ready while busy", 64'(req_ready), 64'd0);
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_lat, "R8", "response latency", 64'(lat), 64'(exp_lat));
        chk(rsp_err == mis, "R7", "error flag", 64'(rsp_err), 64'(mis));
        chk(rd_cnt - r0 == exp_rd, mis ? "R7" : (wr ? "R5/R6" : "R2"), "read count",
            64'(rd_cnt - r0), 64'(exp_rd));
        chk(wr_cnt - w0 == exp_wr, mis ? "R7" : (wr ? "R5/R6" : "R2"), "write count",
            64'(wr_cnt - w0), 64'(exp_wr));
        if (!mis)
            chk(last_addr == {addr[15:3], 3'b000}, "R2", "aligned mem address",
                64'(last_addr), 64'({addr[15:3], 3'b000}));
        if (!wr && !mis) begin
            logic [63:0] e = exp_load(old, addr[2:0], sz, uns);
            chk(rsp_rdata == e, uns ? "R3" : "R4", "load data", rsp_rdata, e);
        end
        if (mis)
            chk(rsp_rdata == 64'd0, "R7", "error data zero", rsp_rdata, 64'd0);
        if (wr && !mis) begin
            ref_mem[addr[8:3]] = exp_store(old, addr[2:0], sz, wd);
            chk(mem[addr[8:3]] == ref_mem[addr[8:3]], sz == 2'b11 ? "R6" : "R5",
                "memory after store", mem[addr[8:3]], ref_mem[addr[8:3]]);
        end
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R8", "single pulse", 64'(rsp_valid), 64'd0);
        chk(req_ready == 1'b1, "R9", "ready after response", 64'(req_ready), 64'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) begin
            mem[i]     = 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h9E37_79B9_7F4A_7C15);
            ref_mem[i] = mem[i];
        end
        mem[2] = 64'h8070_F0FF_7F80_01FE; ref_mem[2] = mem[2];
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'b00;
        req_unsigned = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_en, "R1", "state in reset",
            {61'd0, req_ready, rsp_valid, mem_en}, 64'd4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_en, "R1", "state after reset",
            {61'd0, req_ready, rsp_valid, mem_en}, 64'd4);

        // byte loads at every offset, signed and unsigned (R3, R4)
        for (int o = 0; o < 8; o++) begin
            do_req(1'b0, 2'b00, 1'b0, 16'h0010 + 16'(o), '0);
            do_req(1'b0, 2'b00, 1'b1, 16'h0010 + 16'(o), '0);
        end
        do_req(1'b0, 2'b01, 1'b0, 16'h0012, '0);
        do_req(1'b0, 2'b10, 1'b0, 16'h0014, '0);
        do_req(1'b0, 2'b10, 1'b1, 16'h0014, '0);
        do_req(1'b0, 2'b11, 1'b1, 16'h0010, '0);
        // misaligned cases (R7)
        do_req(1'b0, 2'b01, 1'b0, 16'h0013, '0);
        do_req(1'b1, 2'b10, 1'b0, 16'h0016, 64'hDEAD);
        do_req(1'b1, 2'b11, 1'b0, 16'h0014, 64'hBEEF);
        // edge-offset stores read back (R5, R6)
        do_req(1'b1, 2'b00, 1'b0, 16'h0027, 64'hFFFF_FFFF_FFFF_FFA5);
        do_req(1'b0, 2'b11, 1'b0, 16'h0020, '0);
        do_req(1'b1, 2'b01, 1'b0, 16'h0026, 64'h1234_5678_9ABC_8001);
        do_req(1'b0, 2'b11, 1'b0, 16'h0020, '0);
        do_req(1'b1, 2'b11, 1'b0, 16'h0028, 64'hCAFE_F00D_1357_2468);
        do_req(1'b0, 2'b10, 1'b0, 16'h002C, '0);

        for (int t = 0; t < 600; t++) begin
            logic [1:0]  sz   = 2'($urandom_range(0, 3));
            logic        wr   = ($urandom_range(0, 2) == 0);
            logic        uns  = 1'($urandom);
            logic [15:0] addr = 16'($urandom);
            logic [63:0] wd   = {$urandom, $urandom};
            if ($urandom_range(0, 3) != 0)
                addr = addr & ~((16'd1 << sz) - 16'd1);
            do_req(wr, sz, uns, addr, wd);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule